// File: doc/BRIEF.md
# Compare-Capture Timer with PWM and One-Pulse Modes

This block is an 8-bit up-counting timer. It has two compare channels, two capture inputs and one control byte that selects the operating mode. The counter advances on a tick produced by an internal prescaler. The tick comes either from a fixed division of the system clock or from a divided count of pulses supplied by an external oscillator.

In plain compare mode, each channel loads its programmed level into its output state when the counter matches that channel's compare value. In PWM mode the counter restarts after it matches compare 2, and output 1 alternates between the two programmed levels, which gives a cyclic waveform. In one-pulse mode, a selected edge on capture input 1 restarts the counter and emits a single pulse on output 1. Each capture input latches the counter value on its chosen edge. The pin-enable bits only gate what reaches each output pin.

Software writes and reads the registers through a simple single-cycle port. Reads are combinational on the read address.

Top module: `cctimer_top`

## Requirements
- R1: After reset the control byte (address 0) reads 0x00, both output pins are low and both pin output-enables are low.
- R2: Register map: 0 = control, 1 = compare 1, 2 = compare 2, 3 = capture 1, 4 = capture 2, 5 = counter, 6 = level byte. In the control byte, bit 7 enables pin 1, bit 6 enables pin 2, bit 5 selects one-pulse, bit 4 selects PWM, bits 3:2 select the clock and bit 1 selects the capture 2 edge (1 = rising, 0 = falling). Bit 0 always reads 0. In the level byte, bit 0 is level 1, bit 1 is level 2 and bit 2 selects the capture 1 edge (1 = rising).
- R3: The clock select sets the tick rate: 00 ticks every 4 clocks, 01 every 2 clocks, 10 every 8 clocks, and 11 once every EXT_DIV pulses of osc_tick (default 8000).
- R4: In compare mode, the tick taken while the counter equals compare N sets output state N to level N, and that state then holds.
- R5: In PWM mode the counter reloads to 0 on the tick taken at a compare 2 match. Output 1 holds level 1 while the counter is between 0 and compare 1, and level 2 above that. The period is (compare 2 + 1) ticks.
- R6: In PWM mode, when compare 1 is greater than or equal to compare 2, output 1 stays at level 1 all the time.
- R7: In one-pulse mode output 1 idles at level 1. A capture 1 edge of the selected polarity restarts the counter and prescaler and drives level 2 for exactly (compare 1 + 1) × divisor clocks. The opposite edge starts nothing.
- R8: A trigger edge that arrives while a one-pulse is in progress is ignored. The pulse keeps its original end.
- R9: A capture input latches the counter value once per qualifying edge. A non-selected edge, or an input held at its new level, leaves the capture register unchanged.
- R10: A cleared pin-enable bit forces its pin and output-enable low. The compare logic behind the pin keeps running.
- R11: With both the PWM bit and the one-pulse bit set, the block behaves as in PWM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data, combinational on rd_addr |
| osc_tick | input | 1 | One-cycle pulse per external oscillator period, synchronous to clk |
| cap1_in | input | 1 | Capture input 1, also the one-pulse trigger |
| cap2_in | input | 1 | Capture input 2 |
| cmp1_pin | output | 1 | Output 1 pin value |
| cmp1_oe | output | 1 | Output 1 pin drive enable |
| cmp2_pin | output | 1 | Output 2 pin value |
| cmp2_oe | output | 1 | Output 2 pin drive enable |
| tick_out | output | 1 | Prescaled counter tick enable |

## Verification
The assertions assume two things about the inputs. First, osc_tick arrives as isolated single-cycle pulses in the clock domain. Second, each capture input holds a new level for at least three clocks, so the synchronizer sees every edge. The bench drives osc_tick once every three clocks and holds every capture level for four or more clocks. It changes compare values and levels only before a measurement window, never inside one. Before each window it waits long enough for the counter to pass a full wrap, so each measured period starts from a settled waveform.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_W  = 8;   // counter and register width
    localparam int NCAP   = 2;   // number of capture inputs
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP1 = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP2 = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAP1 = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAP2 = 3'd4;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd5;
    localparam logic [ADDR_W-1:0] A_LVL  = 3'd6;

    typedef enum logic [1:0] {
        CK_DIV4 = 2'b00,
        CK_DIV2 = 2'b01,
        CK_DIV8 = 2'b10,
        CK_EXT  = 2'b11
    } clk_sel_e;

    typedef enum logic [1:0] {
        MD_CMP = 2'd0,
        MD_PWM = 2'd1,
        MD_ONE = 2'd2
    } mode_e;

    typedef struct packed {
        logic     pin1_en;
        logic     pin2_en;
        logic     one_shot;
        logic     pwm;
        clk_sel_e ck;
        logic     cap2_rise;
        logic     rsvd;
    } ctrl_t;

    typedef struct packed {
        logic cap1_rise;
        logic lvl2;
        logic lvl1;
    } lvl_t;

    function automatic ctrl_t to_ctrl(input logic [TMR_W-1:0] w);
        ctrl_t c;
        c      = ctrl_t'(w);
        c.rsvd = 1'b0;
        return c;
    endfunction

    // PWM wins when both mode bits are set
    function automatic mode_e decode_mode(input ctrl_t c);
        if (c.pwm)           return MD_PWM;
        else if (c.one_shot) return MD_ONE;
        else                 return MD_CMP;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int EXT_DIV = 8000
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e sel,
    input  logic     osc_tick,
    input  logic     restart,
    output logic     tick
);
    localparam int PW = (EXT_DIV > 8) ? $clog2(EXT_DIV) : 4;

    logic [PW-1:0] pre_q;
    logic [PW-1:0] lim_m1;
    logic          adv;

    always_comb begin
        unique case (sel)
            CK_DIV4: lim_m1 = PW'(3);
            CK_DIV2: lim_m1 = PW'(1);
            CK_DIV8: lim_m1 = PW'(7);
            default: lim_m1 = PW'(EXT_DIV - 1);
        endcase
    end

    assign adv  = (sel == CK_EXT) ? osc_tick : 1'b1;
    assign tick = adv && (pre_q >= lim_m1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
        end else if (adv) begin
            if (pre_q >= lim_m1) pre_q <= '0;
            else                 pre_q <= pre_q + PW'(1);
        end
    end

    // every divisor is at least two, so ticks are never back to back
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pin_in,
    input  logic         rise_sel,
    input  logic [W-1:0] cnt,
    output logic         hit,
    output logic [W-1:0] value
);
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin_in;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign hit = rise_sel ? (s2_q & ~prev_q) : (~s2_q & prev_q);

    always_ff @(posedge clk) begin
        if (rst)      value <= '0;
        else if (hit) value <= cnt;
    end

    assert_cap_once_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(value) |-> $past(hit));

endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  mode_e        mode,
    input  logic [W-1:0] cmp1,
    input  logic [W-1:0] cmp2,
    input  logic         lvl1,
    input  logic         lvl2,
    input  logic         trig,
    output logic         start,
    output logic [W-1:0] cnt,
    output logic         st1,
    output logic         st2
);
    logic busy_q;
    logic hit1, hit2;

    assign hit1  = tick && (cnt == cmp1);
    assign hit2  = tick && (cnt == cmp2);
    assign start = (mode == MD_ONE) && trig && !busy_q;

    // counter
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (tick) begin
            if (mode == MD_PWM && cnt == cmp2) cnt <= '0;
            else                               cnt <= cnt + W'(1);
        end
    end

    // channel 2: plain compare in every mode
    always_ff @(posedge clk) begin
        if (rst)       st2 <= 1'b0;
        else if (hit2) st2 <= lvl2;
    end

    // channel 1: role depends on the mode
    always_ff @(posedge clk) begin
        if (rst) begin
            st1    <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            unique case (mode)
                MD_PWM: begin
                    busy_q <= 1'b0;
                    if (hit2)      st1 <= lvl1;
                    else if (hit1) st1 <= lvl2;
                end
                MD_ONE: begin
                    if (start) begin
                        st1    <= lvl2;
                        busy_q <= 1'b1;
                    end else if (busy_q && hit1) begin
                        st1    <= lvl1;
                        busy_q <= 1'b0;
                    end else if (!busy_q) begin
                        st1    <= lvl1;
                    end
                end
                default: begin
                    busy_q <= 1'b0;
                    if (hit1) st1 <= lvl1;
                end
            endcase
        end
    end

    assert_pwm_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_PWM && tick && cnt == cmp2) |=> (cnt == '0));

    assert_pulse_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_ONE && busy_q && !hit1) |=> busy_q);

endmodule

// File: rtl/cctimer_top.sv
module cctimer_top
    import tmr_pkg::*;
#(
    parameter int EXT_DIV = 8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TMR_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [TMR_W-1:0]  rd_data,
    input  logic              osc_tick,
    input  logic              cap1_in,
    input  logic              cap2_in,
    output logic              cmp1_pin,
    output logic              cmp1_oe,
    output logic              cmp2_pin,
    output logic              cmp2_oe,
    output logic              tick_out
);
    ctrl_t            ctrl_q;
    lvl_t             lvl_q;
    logic [TMR_W-1:0] cmp1_q, cmp2_q;
    mode_e            mode;
    logic             tick, start, st1, st2;
    logic [TMR_W-1:0] cnt;
    logic [NCAP-1:0]  cap_pins, cap_rise, cap_hit;
    logic [TMR_W-1:0] cap_val [NCAP];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            lvl_q  <= '0;
            cmp1_q <= '0;
            cmp2_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL:  ctrl_q <= to_ctrl(wr_data);
                A_CMP1:  cmp1_q <= wr_data;
                A_CMP2:  cmp2_q <= wr_data;
                A_LVL:   lvl_q  <= lvl_t'(wr_data[2:0]);
                default: ;
            endcase
        end
    end

    assign mode = decode_mode(ctrl_q);

    tmr_prescale #(.EXT_DIV(EXT_DIV)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .sel      (ctrl_q.ck),
        .osc_tick (osc_tick),
        .restart  (start),
        .tick     (tick)
    );

    assign cap_pins = {cap2_in, cap1_in};
    assign cap_rise = {ctrl_q.cap2_rise, lvl_q.cap1_rise};

    generate
        for (genvar g = 0; g < NCAP; g++) begin : g_cap
            tmr_capture #(.W(TMR_W)) u_cap (
                .clk      (clk),
                .rst      (rst),
                .pin_in   (cap_pins[g]),
                .rise_sel (cap_rise[g]),
                .cnt      (cnt),
                .hit      (cap_hit[g]),
                .value    (cap_val[g])
            );
        end
    endgenerate

    tmr_wave #(.W(TMR_W)) u_wave (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .mode  (mode),
        .cmp1  (cmp1_q),
        .cmp2  (cmp2_q),
        .lvl1  (lvl_q.lvl1),
        .lvl2  (lvl_q.lvl2),
        .trig  (cap_hit[0]),
        .start (start),
        .cnt   (cnt),
        .st1   (st1),
        .st2   (st2)
    );

    // pin gating only; compare state keeps running behind it
    assign cmp1_oe  = ctrl_q.pin1_en;
    assign cmp2_oe  = ctrl_q.pin2_en;
    assign cmp1_pin = ctrl_q.pin1_en & st1;
    assign cmp2_pin = ctrl_q.pin2_en & st2;
    assign tick_out = tick;

    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = ctrl_q;
            A_CMP1:  rd_data = cmp1_q;
            A_CMP2:  rd_data = cmp2_q;
            A_CAP1:  rd_data = cap_val[0];
            A_CAP2:  rd_data = cap_val[1];
            A_CNT:   rd_data = cnt;
            A_LVL:   rd_data = {{(TMR_W-3){1'b0}}, lvl_q};
            default: rd_data = '0;
        endcase
    end

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == A_CTRL) |-> (rd_data[0] == 1'b0));

    assert_pin_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (!cmp1_oe |-> !cmp1_pin) and (!cmp2_oe |-> !cmp2_pin));

    assert_cap2_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !cap_hit[1] |=> $stable(cap_val[1]));

endmodule

// File: tb/sim_cctimer_top.sv
module sim_cctimer_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       osc_tick = 1'b0;
    logic       cap1_in = 1'b0;
    logic       cap2_in = 1'b0;
    logic       cmp1_pin, cmp1_oe, cmp2_pin, cmp2_oe, tick_out;

    int  checks = 0;
    int  errors = 0;
    bit  osc_run = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    cctimer_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .osc_tick(osc_tick),
        .cap1_in(cap1_in), .cap2_in(cap2_in), .cmp1_pin(cmp1_pin), .cmp1_oe(cmp1_oe),
        .cmp2_pin(cmp2_pin), .cmp2_oe(cmp2_oe), .tick_out(tick_out)
    );

    // PWM vectors: {cmp1, cmp2, clock select, level1, level2}
    localparam logic [19:0] PWM_VEC [5] = '{
        {8'd9,   8'd39, 2'b01, 1'b1, 1'b0},
        {8'd29,  8'd49, 2'b00, 1'b1, 1'b0},
        {8'd3,   8'd19, 2'b10, 1'b0, 1'b1},
        {8'd60,  8'd60, 2'b01, 1'b1, 1'b0},
        {8'd200, 8'd15, 2'b01, 1'b0, 1'b1}
    };

    // external oscillator: one pulse every three clocks, changed away from edges
    initial forever begin
        @(posedge clk); #2;
        if (osc_run) begin
            osc_tick = 1'b0;
            @(posedge clk); #2;
            @(posedge clk); #2;
            osc_tick = osc_run;
        end else begin
            osc_tick = 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_count(input int val);
        int v;
        rd(3'd5, v);
        for (int k = 0; k < 5000 && v != val; k++) begin
            @(negedge clk);
            rd(3'd5, v);
        end
    endtask

    task automatic tick_gap(output int n);
        for (int k = 0; k < 30000 && !tick_out; k++) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_out && n < 30000);
    endtask

    function automatic int divof(input logic [1:0] s);
        case (s)
            2'b00:   return 4;
            2'b01:   return 2;
            default: return 8;
        endcase
    endfunction

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (cmp1_pin) hi++;
        end
    endtask

    initial begin
        int v, a, b, n, hi, bad;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v);
        chk("R1 ctrl", v, 0);
        chk("R1 pins", {cmp1_pin, cmp1_oe, cmp2_pin, cmp2_oe}, 0);

        // R2 reserved bit and enable fields
        wr(3'd0, 8'hFF);
        rd(3'd0, v);
        chk("R2 ctrl readback", v, 8'hFE);
        chk("R2 enables", {cmp1_oe, cmp2_oe}, 3);
        wr(3'd0, 8'h00);

        // R3 tick rates
        for (int s = 0; s < 3; s++) begin
            wr(3'd0, 8'(s << 2));
            cyc(10);
            tick_gap(n);
            chk("R3 tick gap", n, divof(2'(s)));
        end
        wr(3'd0, 8'h0C);
        osc_run = 1'b1;
        tick_gap(n);
        tick_gap(n);
        chk("R3 external tick gap", n, 3 * 8000);
        osc_run = 1'b0;
        cyc(4);

        // R4 compare mode, both levels high
        wr(3'd6, 8'h03);
        wr(3'd1, 8'd10);
        wr(3'd2, 8'd20);
        wr(3'd0, 8'hC4);
        wait_count(10);
        chk("R4 before match", cmp1_pin, 0);
        wait_count(11);
        chk("R4 after match ch1", cmp1_pin, 1);
        wait_count(21);
        chk("R4 after match ch2", cmp2_pin, 1);

        // R10 pin 2 disabled, compare keeps working behind it
        wr(3'd0, 8'h84);
        chk("R10 disabled pin", {cmp2_pin, cmp2_oe}, 0);
        wr(3'd6, 8'h01);
        wait_count(22);
        wr(3'd0, 8'hC4);
        chk("R10 hidden compare applied", {cmp2_pin, cmp2_oe}, 1);

        // R5 / R6 PWM vector table
        for (int i = 0; i < 5; i++) begin
            logic [7:0] c1, c2;
            logic [1:0] sel;
            logic       l1, l2;
            int d, per, lo1, exp_hi, first, second;
            logic prev;
            {c1, c2, sel, l1, l2} = PWM_VEC[i];
            d = divof(sel);
            wr(3'd1, c1);
            wr(3'd2, c2);
            wr(3'd6, {6'd0, l2, l1});
            wr(3'd0, {4'b1001, sel, 2'b00});
            cyc(520 * d);
            per    = int'(c2) + 1;
            lo1    = (int'(c1) + 1 < per) ? int'(c1) + 1 : per;
            exp_hi = 3 * d * (l1 * lo1 + l2 * (per - lo1));
            hi = 0; first = -1; second = -1; prev = cmp1_pin;
            for (int k = 0; k < 3 * per * d; k++) begin
                @(negedge clk);
                if (cmp1_pin) hi++;
                if (cmp1_pin && !prev) begin
                    if (first < 0) first = k;
                    else if (second < 0) second = k;
                end
                prev = cmp1_pin;
            end
            if (c1 >= c2) begin
                chk("R6 flat output", hi, exp_hi);
            end else begin
                chk("R5 duty", hi, exp_hi);
                chk("R5 period", second - first, per * d);
            end
        end

        // R10 / R11 both mode bits, pin first disabled
        wr(3'd6, 8'h01);
        wr(3'd1, 8'd9);
        wr(3'd2, 8'd39);
        wr(3'd0, 8'h34);
        bad = 0;
        for (int k = 0; k < 1200; k++) begin
            @(negedge clk);
            if (cmp1_pin || cmp1_oe) bad++;
        end
        chk("R10 pin1 held off", bad, 0);
        wr(3'd0, 8'hB4);
        bad = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            rd(3'd5, v);
            if (int'(cmp1_pin) != int'(v <= 9)) bad++;
        end
        chk("R11 PWM wins, R10 compare ran while gated", bad, 0);

        // R7 / R8 one-pulse, rising trigger
        wr(3'd6, 8'h06);
        wr(3'd1, 8'd5);
        wr(3'd0, 8'hA4);
        cyc(20);
        chk("R7 idle level", cmp1_pin, 0);
        cap1_in = 1'b1;
        count_high(60, hi);
        chk("R7 pulse width rising", hi, 12);
        cap1_in = 1'b0;
        count_high(20, hi);
        chk("R7 opposite edge no pulse", hi, 0);
        cap1_in = 1'b1;
        count_high(4, a);
        cap1_in = 1'b0;
        count_high(4, b);
        cap1_in = 1'b1;
        count_high(52, hi);
        chk("R8 retrigger ignored", a + b + hi, 12);

        // R7 falling trigger
        wr(3'd6, 8'h02);
        wr(3'd1, 8'd9);
        cyc(10);
        cap1_in = 1'b0;
        count_high(80, hi);
        chk("R7 pulse width falling", hi, 20);
        cap1_in = 1'b1;
        count_high(40, hi);
        chk("R7 rising ignored when falling selected", hi, 0);

        // R9 capture 2, counter frozen in external mode with no oscillator
        wr(3'd0, 8'h06);
        cyc(37);
        wr(3'd0, 8'h0E);
        rd(3'd5, a);
        cap2_in = 1'b1;
        cyc(6);
        rd(3'd4, v);
        chk("R9 rising capture", v, a);
        wr(3'd0, 8'h06);
        cyc(41);
        wr(3'd0, 8'h0E);
        rd(3'd5, b);
        cap2_in = 1'b0;
        cyc(6);
        rd(3'd4, v);
        chk("R9 falling not selected", v, a);
        wr(3'd0, 8'h0C);
        cap2_in = 1'b1;
        cyc(6);
        cap2_in = 1'b0;
        cyc(6);
        rd(3'd4, v);
        chk("R9 falling capture", v, b);
        wr(3'd0, 8'h04);
        cyc(60);
        wr(3'd0, 8'h0C);
        rd(3'd4, v);
        chk("R9 held level captures once", v, b);

        // R9 capture 1 on falling edge
        rd(3'd5, a);
        wr(3'd6, 8'h00);
        cap1_in = 1'b0;
        cyc(6);
        rd(3'd3, v);
        chk("R9 capture1 falling", v, a);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule